// File: doc/BRIEF.md
# Long-Mode Data Access Fault Checker

This block decides whether a data access issued in 64-bit mode must fault before it is handed on to translation. Each request carries a linear address, a length in bytes, the kind of segment it uses, an alignment-check enable, the current privilege level and a flag that marks accesses which must be naturally aligned. One cycle later the block reports either a single fault (its vector, with an error code of zero) or that the access may proceed.

The checks run in a fixed order and only the first one that hits is reported. First, an access flagged as alignment-required that is misaligned faults with general protection. Second, the first byte's address is tested for canonical form. Third, the alignment-check fault is raised when enabled. Fourth, the address of the last byte is also tested for canonical form. A canonical failure maps to a stack fault for stack and new-stack accesses and to general protection otherwise. Lengths are powers of two from 1 to 64 bytes.

Top module: `lm_access_fault_chk`

## Requirements
- R1: While reset is asserted and after it is released with no request, rsp_valid, rsp_fault and rsp_pass are 0 and rsp_vector is 0.
- R2: A request sampled with req_valid high at a rising edge produces rsp_valid high for exactly the following cycle; without a request rsp_valid stays low.
- R3: An address is canonical only when bits 63 down to 47 are all equal; a request whose first byte is not canonical faults.
- R4: A request whose first byte is canonical but whose last byte (address + length - 1, modulo 2^64) is not canonical faults.
- R5: A canonical failure reports vector 12 (stack fault) when req_seg is 2'b01 (stack) or 2'b10 (new-stack), and vector 13 (general protection) when req_seg is 2'b00 or 2'b11.
- R6: With req_ac_en high and (address AND (length - 1)) nonzero, the alignment-check fault, vector 17, is reported; with req_ac_en low no vector 17 is ever reported.
- R7: For new-stack requests (req_seg 2'b10) the alignment-check fault is raised only when req_cpl is 3.
- R8: A request with req_aligned high whose address is not a multiple of its length reports vector 13, ahead of both canonical tests.
- R9: A one-byte request never reports the alignment-check fault.
- R10: Only the first hit in the order aligned-required, first-byte canonical, alignment check, last-byte canonical is reported.
- R11: rsp_errcode is always 0; rsp_pass is high exactly when rsp_valid is high and rsp_fault is low, and rsp_vector is 0 whenever no fault is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Linear address of the first byte |
| req_len | input | 7 | Access length in bytes, power of two 1..64 |
| req_seg | input | 2 | Segment kind: 00 normal, 01 stack, 10 new-stack, 11 normal |
| req_ac_en | input | 1 | Alignment checking enabled |
| req_cpl | input | 2 | Current privilege level |
| req_aligned | input | 1 | Access must be naturally aligned |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_fault | output | 1 | The access faults |
| rsp_vector | output | 8 | Fault vector (12, 13 or 17), 0 when no fault |
| rsp_errcode | output | 16 | Fault error code, always 0 |
| rsp_pass | output | 1 | The access is passed on without fault |

## Verification
The bench aims at the boundaries of the canonical hole: addresses just below 0x0000_8000_0000_0000 whose tail crosses it, which a design testing only the first byte would let through, and addresses just above 0xFFFF_8000_0000_0000 that must pass. It sets faults against each other, such as a misaligned alignment-required stack access with a non-canonical address, where a wrong order would give 12 instead of 13, and an alignment-check hit whose last byte is also non-canonical, where a wrong order would give a stack fault instead of 17. New-stack requests at privilege levels 0 and 3 expose a design that ignores the privilege gate, and one-byte requests at odd addresses expose one that applies alignment checking to bytes.

// File: rtl/lm_fault_pkg.sv
package lm_fault_pkg;

  typedef enum logic [1:0] {
    SEG_NORMAL = 2'b00,
    SEG_STACK  = 2'b01,
    SEG_NEWSTK = 2'b10,
    SEG_OTHER  = 2'b11
  } seg_kind_e;

  localparam int VEC_W = 8;

  localparam logic [VEC_W-1:0] VEC_NONE = 8'd0;
  localparam logic [VEC_W-1:0] VEC_SS   = 8'd12;
  localparam logic [VEC_W-1:0] VEC_GP   = 8'd13;
  localparam logic [VEC_W-1:0] VEC_AC   = 8'd17;

  // Index of each check in the priority chain (lower index wins)
  localparam int CHK_ALIGN_REQ = 0;
  localparam int CHK_CANON_LO  = 1;
  localparam int CHK_ALIGN_CHK = 2;
  localparam int CHK_CANON_HI  = 3;
  localparam int NUM_CHK       = 4;

endpackage

// File: rtl/lm_canon_test.sv
// Canonical-form test: the bits from the top down to the highest
// implemented virtual address bit must all be equal.
module lm_canon_test #(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              canon_ok
);
  localparam int TOP_W = ADDR_W - VA_BITS + 1;

  logic [TOP_W-1:0] top_bits;

  always_comb begin
    top_bits = addr[ADDR_W-1:VA_BITS-1];
    canon_ok = (&top_bits) | ~(|top_bits);
  end

endmodule

// File: rtl/lm_align_test.sv
// Misalignment test for power-of-two lengths: any address bit under
// the length's own bit means the access is not naturally aligned.
module lm_align_test #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              misaligned
);
  logic [LEN_W-1:0] len_mask;

  always_comb begin
    len_mask   = len - LEN_W'(1);
    misaligned = |(addr[LEN_W-1:0] & len_mask);
  end

endmodule

// File: rtl/lm_fault_prio.sv
// Picks the vector of the lowest-indexed asserted check.
module lm_fault_prio #(
  parameter int N     = 4,
  parameter int VEC_W = 8
) (
  input  logic [N-1:0]       hit,
  input  logic [N*VEC_W-1:0] vec_tbl,
  output logic               fault,
  output logic [VEC_W-1:0]   vector
);
  always_comb begin
    vector = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) vector = vec_tbl[i*VEC_W +: VEC_W];
    end
    fault = |hit;
  end

endmodule

// File: rtl/lm_access_fault_chk.sv
module lm_access_fault_chk
  import lm_fault_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VA_BITS = 48,
  parameter int LEN_W   = 7,
  parameter int ERR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_seg,
  input  logic              req_ac_en,
  input  logic [1:0]        req_cpl,
  input  logic              req_aligned,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [VEC_W-1:0]  rsp_vector,
  output logic [ERR_W-1:0]  rsp_errcode,
  output logic              rsp_pass
);
  localparam int NUM_PROBE = 2;   // first byte, last byte
  localparam logic [1:0] CPL_USER = 2'd3;

  // ---------------------------------------------------------------
  // Probe addresses and canonical tests
  // ---------------------------------------------------------------
  logic [ADDR_W-1:0] probe_addr [NUM_PROBE];
  logic [NUM_PROBE-1:0] canon_ok;

  always_comb begin
    probe_addr[0] = req_addr;
    probe_addr[1] = req_addr + {{(ADDR_W-LEN_W){1'b0}}, req_len} - ADDR_W'(1);
  end

  for (genvar g = 0; g < NUM_PROBE; g++) begin : g_probe
    lm_canon_test #(
      .ADDR_W  (ADDR_W),
      .VA_BITS (VA_BITS)
    ) u_canon (
      .addr     (probe_addr[g]),
      .canon_ok (canon_ok[g])
    );
  end

  // ---------------------------------------------------------------
  // Alignment
  // ---------------------------------------------------------------
  logic misaligned;

  lm_align_test #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_align (
    .addr       (req_addr),
    .len        (req_len),
    .misaligned (misaligned)
  );

  // ---------------------------------------------------------------
  // Check decode
  // ---------------------------------------------------------------
  seg_kind_e seg;
  logic      stack_kind;
  logic      ac_allowed;
  logic [VEC_W-1:0] canon_vec;
  logic [NUM_CHK-1:0]       chk_hit;
  logic [NUM_CHK*VEC_W-1:0] chk_vec;

  always_comb begin
    seg        = seg_kind_e'(req_seg);
    stack_kind = (seg == SEG_STACK) || (seg == SEG_NEWSTK);
    canon_vec  = stack_kind ? VEC_SS : VEC_GP;
    ac_allowed = req_ac_en && (req_len > LEN_W'(1)) &&
                 ((seg != SEG_NEWSTK) || (req_cpl == CPL_USER));

    chk_hit = '0;
    chk_hit[CHK_ALIGN_REQ] = req_aligned & misaligned;
    chk_hit[CHK_CANON_LO]  = ~canon_ok[0];
    chk_hit[CHK_ALIGN_CHK] = ac_allowed & misaligned;
    chk_hit[CHK_CANON_HI]  = ~canon_ok[1];

    chk_vec = '0;
    chk_vec[CHK_ALIGN_REQ*VEC_W +: VEC_W] = VEC_GP;
    chk_vec[CHK_CANON_LO*VEC_W  +: VEC_W] = canon_vec;
    chk_vec[CHK_ALIGN_CHK*VEC_W +: VEC_W] = VEC_AC;
    chk_vec[CHK_CANON_HI*VEC_W  +: VEC_W] = canon_vec;
  end

  logic             sel_fault;
  logic [VEC_W-1:0] sel_vector;

  lm_fault_prio #(
    .N     (NUM_CHK),
    .VEC_W (VEC_W)
  ) u_prio (
    .hit     (chk_hit),
    .vec_tbl (chk_vec),
    .fault   (sel_fault),
    .vector  (sel_vector)
  );

  // ---------------------------------------------------------------
  // Result register: next state, then flops
  // ---------------------------------------------------------------
  logic             valid_q, valid_d;
  logic             fault_q, fault_d;
  logic [VEC_W-1:0] vec_q,   vec_d;
  logic             load_en;

  always_comb begin
    load_en = req_valid;
    valid_d = req_valid;
    fault_d = fault_q;
    vec_d   = vec_q;
    if (load_en) begin
      fault_d = sel_fault;
      vec_d   = sel_vector;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      vec_q   <= VEC_NONE;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
      vec_q   <= vec_d;
    end
  end

  always_comb begin
    rsp_valid   = valid_q;
    rsp_fault   = valid_q & fault_q;
    rsp_vector  = (valid_q & fault_q) ? vec_q : VEC_NONE;
    rsp_pass    = valid_q & ~fault_q;
    rsp_errcode = '0;
  end

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);  // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);  // R2
  AST_FAULT_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_vector == VEC_SS || rsp_vector == VEC_GP || rsp_vector == VEC_AC));  // R11
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pass |-> (!rsp_fault && rsp_vector == VEC_NONE));  // R11
  AST_ALIGN_REQ_GP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_aligned && misaligned) |=> (rsp_vector == VEC_GP));  // R8
  AST_NEWSTK_CANON_SS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seg == SEG_NEWSTK && !canon_ok[0] && !(req_aligned && misaligned))
      |=> (rsp_vector == VEC_SS));  // R5
  AST_BYTE_NO_AC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len == LEN_W'(1)) |=> (rsp_vector != VEC_AC));  // R9
  AST_AC_OFF_NO_AC: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ac_en) |=> (rsp_vector != VEC_AC));  // R6

endmodule

// File: tb/lm_access_fault_chk_tb.sv
module lm_access_fault_chk_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic [6:0]  req_len = 7'd1;
  logic [1:0]  req_seg = '0;
  logic        req_ac_en = 1'b0;
  logic [1:0]  req_cpl = '0;
  logic        req_aligned = 1'b0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [7:0]  rsp_vector;
  logic [15:0] rsp_errcode;
  logic        rsp_pass;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;
  bit chk_on = 0;

  // expectation driven with the stimulus, staged one edge like the DUT
  bit    drv_valid = 0;
  int    drv_vec = 0;
  string drv_tag = "R2";
  bit    stg_valid = 0;
  int    stg_vec = 0;
  string stg_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  lm_access_fault_chk dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .req_seg     (req_seg),
    .req_ac_en   (req_ac_en),
    .req_cpl     (req_cpl),
    .req_aligned (req_aligned),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_vector  (rsp_vector),
    .rsp_errcode (rsp_errcode),
    .rsp_pass    (rsp_pass)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit is_canon(input logic [63:0] a);
    return (a[63:47] == 17'h0) || (a[63:47] == 17'h1ffff);
  endfunction

  // Behavioural reference: walk the checks in the stated order
  function automatic int model_vec(input logic [63:0] a, input int len, input int seg,
                                   input bit ac, input int cpl, input bit algn);
    logic [63:0] last;
    int  cv;
    bit  off;
    last = a + 64'(len) - 64'd1;
    cv   = (seg == 1 || seg == 2) ? 12 : 13;
    off  = (a % 64'(len)) != 0;
    if (algn && off) return 13;
    if (!is_canon(a)) return cv;
    if (ac && len > 1 && (seg != 2 || cpl == 3) && off) return 17;
    if (!is_canon(last)) return cv;
    return 0;
  endfunction

  always @(posedge clk) begin
    stg_valid <= drv_valid;
    stg_vec   <= drv_vec;
    stg_tag   <= drv_tag;
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk(stg_valid ? stg_tag : "R2", "rsp_valid", rsp_valid, stg_valid);
      if (stg_valid) begin
        chk(stg_tag, "rsp_vector", rsp_vector, stg_vec);
        chk(stg_tag, "rsp_fault", rsp_fault, stg_vec != 0);
        chk("R11", "rsp_pass", rsp_pass, stg_vec == 0);
        chk("R11", "rsp_errcode", rsp_errcode, 0);
      end else begin
        chk("R2", "idle rsp_fault", rsp_fault, 0);
        chk("R2", "idle rsp_pass", rsp_pass, 0);
      end
    end
  end

  task automatic send(input string tag, input logic [63:0] a, input int len, input int seg,
                      input bit ac, input int cpl, input bit algn);
    @(negedge clk);
    req_valid   = 1'b1;
    req_addr    = a;
    req_len     = 7'(len);
    req_seg     = 2'(seg);
    req_ac_en   = ac;
    req_cpl     = 2'(cpl);
    req_aligned = algn;
    drv_valid   = 1;
    drv_vec     = model_vec(a, len, seg, ac, cpl, algn);
    drv_tag     = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      drv_valid = 0;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    chk("R1", "reset rsp_valid", rsp_valid, 0);
    chk("R1", "reset rsp_fault", rsp_fault, 0);
    chk("R1", "reset rsp_pass", rsp_pass, 0);
    chk("R1", "reset rsp_vector", rsp_vector, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset rsp_valid", rsp_valid, 0);
    chk("R1", "post-reset rsp_vector", rsp_vector, 0);
    chk_on = 1;

    // R11 clean pass
    send("R11", 64'h0000_0000_0000_1000, 8, 0, 0, 0, 0);
    // R3 first byte just past the low half
    send("R3",  64'h0000_8000_0000_0000, 1, 0, 0, 0, 0);
    send("R3",  64'hFFFF_8000_0000_0000, 4, 0, 0, 0, 0);
    send("R3",  64'hFFFF_7FFF_FFFF_FFF0, 4, 0, 0, 0, 0);
    idle(2);
    // R5 vector per segment kind
    send("R5",  64'h0000_8000_0000_0000, 1, 1, 0, 0, 0);
    send("R5",  64'h1234_0000_0000_0000, 2, 2, 0, 3, 0);
    send("R5",  64'h1234_0000_0000_0000, 2, 3, 0, 0, 0);
    // R4 tail crosses into the hole
    send("R4",  64'h0000_7FFF_FFFF_FFFC, 8, 0, 0, 0, 0);
    send("R4",  64'h0000_7FFF_FFFF_FFFC, 8, 1, 0, 0, 0);
    send("R4",  64'h0000_7FFF_FFFF_FFF8, 8, 0, 0, 0, 0);
    // R6 alignment check on and off
    send("R6",  64'h0000_0000_0000_1002, 4, 0, 1, 0, 0);
    send("R6",  64'h0000_0000_0000_1002, 4, 0, 0, 3, 0);
    send("R6",  64'h0000_0000_0000_1004, 4, 1, 1, 3, 0);
    // R7 new-stack gated by privilege
    send("R7",  64'h0000_0000_0000_1002, 4, 2, 1, 0, 0);
    send("R7",  64'h0000_0000_0000_1002, 4, 2, 1, 3, 0);
    send("R7",  64'h0000_0000_0000_1006, 8, 2, 1, 1, 0);
    // R9 byte accesses
    send("R9",  64'h0000_0000_0000_1003, 1, 0, 1, 3, 0);
    send("R9",  64'h0000_0000_0000_1003, 1, 2, 1, 3, 0);
    // R8 aligned-required wins over canonical stack fault
    send("R8",  64'h0000_8000_0000_0008, 16, 1, 0, 0, 1);
    send("R8",  64'h0000_0000_0000_2010, 32, 0, 0, 0, 1);
    send("R8",  64'h0000_0000_0000_2040, 32, 1, 0, 0, 1);
    // R10 ordering between the middle checks
    send("R10", 64'h0000_8000_0000_0002, 4, 1, 1, 0, 0);
    send("R10", 64'h0000_7FFF_FFFF_FFFE, 4, 1, 1, 0, 0);
    send("R10", 64'h0000_7FFF_FFFF_FFF0, 64, 1, 1, 0, 0);
    idle(1);

    // R10 mixed sweep around the boundaries
    for (int n = 0; n < 400; n++) begin
      logic [63:0] base;
      int len;
      case ($urandom % 5)
        0: base = 64'h0000_7FFF_FFFF_FF80;
        1: base = 64'hFFFF_8000_0000_0000;
        2: base = 64'h0000_8000_0000_0000;
        3: base = 64'hFFFF_7FFF_FFFF_FFC0;
        default: base = {$urandom, $urandom};
      endcase
      len = 1 << ($urandom % 7);
      send("R10", base + 64'($urandom % 128), len, int'($urandom % 4),
           1'($urandom), int'($urandom % 4), 1'(($urandom % 4) == 0));
      if (($urandom % 6) == 0) idle(1);
    end
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule